// File: doc/BRIEF.md
# Output Buffer Arbiter and Interrupt Generator

This block sits behind the data port of a keyboard/mouse controller. Four kinds of byte can be waiting to go to the host. A response from the controller can be tagged for the keyboard side or for the auxiliary side. A data byte can come from the keyboard device or from the mouse device. The block holds a pending flag for each of these. Whenever the single-byte output buffer is empty, it moves exactly one byte into the buffer, choosing by a fixed priority. It raises the buffer-full status bit and the mouse-full status bit, and it drives two level-sensitive interrupt lines under control of the mode byte.

The keyboard and mouse devices offer bytes through a valid/ack handshake. The block pulses the ack in the same cycle that it copies the byte into the buffer. The controller posts its own responses with a one-cycle strobe into a single response slot. The host reads the data port with a one-cycle strobe. The read empties the buffer, and the next arbitration happens on the following cycle. As an option, reading a byte that came from the keyboard starts a delay of a parameterised number of cycles. No byte is loaded until that delay runs out.

Top module: `obuf_arbiter`

## Requirements
- R1: After reset the buffer is empty. `obFull`, `auxFull`, `kbdIrq` and `mouseIrq` are 0, and `readData` is 8'h00.
- R2: When several sources are eligible, the byte is taken in this order: controller response for the keyboard side, then controller response for the auxiliary side, then keyboard device, then mouse device.
- R3: While `modeByte` bit 4 (0x10) is set, the keyboard device is never selected. While bit 5 (0x20) is set, the mouse device is never selected. Controller responses are selected whatever these bits are.
- R4: Every load sets `obFull`. `auxFull` is set as well only when the byte is an auxiliary-side controller response or a mouse byte. A device byte offered while the buffer is empty and no throttle delay is running is loaded on the next clock edge. A controller response is loaded on the edge after the edge that records it.
- R5: `kbdIrq` is 1 exactly when `obFull` is 1, `auxFull` is 0, `modeByte` bit 0 is 1 and `modeByte` bit 4 is 0.
- R6: `mouseIrq` is 1 exactly when `obFull` is 1, `auxFull` is 1 and `modeByte` bit 1 is 1. The two lines are never high together.
- R7: A `dataRead` strobe while the buffer is full clears `obFull`, `auxFull` and both interrupts on that edge. If the byte just read did not come from the keyboard device, the next eligible byte is loaded on the following edge.
- R8: While the buffer is full, its byte, `auxFull` and `readData` do not change, and no device ack is given, until the host reads.
- R9: When the throttle parameter is on, reading a keyboard-device byte blocks all arbitration for `THROTTLE_CYCLES` cycles. With the default of 20 in the bench, the next byte is loaded on the 21st edge after the read edge.
- R10: A new controller response overwrites an unread earlier one and drops that one's side tag. Only the newest response is delivered.
- R11: A `dataRead` while the buffer is empty changes no state. `readData` still shows the byte delivered last.
- R12: The interrupt lines follow changes of `modeByte` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeByte | input | 8 | Mode byte: bit0 keyboard interrupt enable, bit1 mouse interrupt enable, bit4 keyboard off, bit5 mouse off |
| ctrlRespValid | input | 1 | One-cycle strobe posting a controller response |
| ctrlRespAux | input | 1 | Side tag of the posted response: 1 auxiliary, 0 keyboard |
| ctrlRespByte | input | 8 | Controller response byte |
| kbdValid | input | 1 | Keyboard device offers a byte |
| kbdByte | input | 8 | Keyboard device byte |
| kbdAck | output | 1 | Keyboard byte taken this cycle |
| mouseValid | input | 1 | Mouse device offers a byte |
| mouseByte | input | 8 | Mouse device byte |
| mouseAck | output | 1 | Mouse byte taken this cycle |
| dataRead | input | 1 | Host read strobe of the data port |
| readData | output | 8 | Buffered byte, or the byte delivered last |
| obFull | output | 1 | Output buffer full status bit |
| auxFull | output | 1 | Buffered byte belongs to the auxiliary side |
| kbdIrq | output | 1 | Keyboard interrupt level |
| mouseIrq | output | 1 | Mouse interrupt level |

## Verification
The assertions check every cycle that the buffer stays frozen while full. They also check that acks only come when the buffer is empty and only for unmasked devices, that a mouse ack is never given while a keyboard byte is eligible, that a loaded device byte shows up with the correct side flag, and that the interrupt lines agree with the buffer state and the mode bits. Other behaviour can only be shown by the bench's scenarios. These are the full priority order including controller responses, the overwriting of an unread response, the exact length of the throttle window, and the re-read of the last byte from an empty buffer. The bench drives each of these while the buffer is held full or while a source is masked, and then drains the buffer in a known order.

// File: rtl/obuf_arb_pkg.sv
`timescale 1ns/1ps
package obuf_arb_pkg;

  // Source index doubles as priority rank: lower index wins.
  typedef enum logic [1:0] {
    SRC_CTRL_KBD = 2'd0,
    SRC_CTRL_AUX = 2'd1,
    SRC_KBD      = 2'd2,
    SRC_MOUSE    = 2'd3
  } srcE;

  localparam int NUM_SRC = 4;

  // Mode byte bit positions the arbiter decodes.
  localparam int MODE_KBD_IRQ_EN = 0;
  localparam int MODE_AUX_IRQ_EN = 1;
  localparam int MODE_KBD_OFF    = 4;
  localparam int MODE_AUX_OFF    = 5;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;         // copy selected byte into the buffer
    srcE  src;          // which byte to copy
    logic respCapture;  // store a new controller response byte
  } strobeT;

endpackage

// File: rtl/obuf_arb_ctrl.sv
`timescale 1ns/1ps
module obuf_arb_ctrl
  import obuf_arb_pkg::*;
#(
  parameter bit THROTTLE_EN     = 1'b0,
  parameter int THROTTLE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] modeByte,
  input  logic       ctrlRespValid,
  input  logic       ctrlRespAux,
  input  logic       kbdValid,
  input  logic       mouseValid,
  input  logic       dataRead,
  output strobeT     strobes,
  output logic       obFull,
  output logic       auxFull,
  output logic       kbdAck,
  output logic       mouseAck,
  output logic       kbdIrq,
  output logic       mouseIrq
);

  localparam int CNT_W = $clog2(THROTTLE_CYCLES + 1);

  logic               ctrlKbdPend;
  logic               ctrlAuxPend;
  logic               fullQ;
  logic               auxQ;
  srcE                srcQ;
  logic [NUM_SRC-1:0] reqVec;
  srcE                winner;
  logic               throttleBusy;
  logic               loadNow;
  logic               readHit;
  logic               unusedModeBits;

  assign unusedModeBits = ^{modeByte[7:6], modeByte[3:2]};

  // Request vector indexed by priority rank.
  always_comb begin
    reqVec[SRC_CTRL_KBD] = ctrlKbdPend;
    reqVec[SRC_CTRL_AUX] = ctrlAuxPend;
    reqVec[SRC_KBD]      = kbdValid   && !modeByte[MODE_KBD_OFF];
    reqVec[SRC_MOUSE]    = mouseValid && !modeByte[MODE_AUX_OFF];
  end

  // Fixed priority: scan from lowest rank down so the smallest index wins.
  always_comb begin
    winner = SRC_MOUSE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) winner = srcE'(i);
    end
  end

  assign loadNow = !fullQ && !throttleBusy && (|reqVec);
  assign readHit = dataRead && fullQ;

  // Single controller response slot; a new post replaces the old tag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlKbdPend <= 1'b0;
      ctrlAuxPend <= 1'b0;
    end else if (ctrlRespValid) begin
      ctrlKbdPend <= !ctrlRespAux;
      ctrlAuxPend <= ctrlRespAux;
    end else if (loadNow && winner == SRC_CTRL_KBD) begin
      ctrlKbdPend <= 1'b0;
    end else if (loadNow && winner == SRC_CTRL_AUX) begin
      ctrlAuxPend <= 1'b0;
    end
  end

  // Buffer occupancy and source tag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ <= 1'b0;
      auxQ  <= 1'b0;
      srcQ  <= SRC_CTRL_KBD;
    end else if (readHit) begin
      fullQ <= 1'b0;
      auxQ  <= 1'b0;
    end else if (loadNow) begin
      fullQ <= 1'b1;
      auxQ  <= (winner == SRC_CTRL_AUX) || (winner == SRC_MOUSE);
      srcQ  <= winner;
    end
  end

  generate
    if (THROTTLE_EN) begin : gThrottle
      logic [CNT_W-1:0] holdCnt;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          holdCnt <= '0;
        end else if (readHit && srcQ == SRC_KBD) begin
          holdCnt <= CNT_W'(THROTTLE_CYCLES);
        end else if (holdCnt != '0) begin
          holdCnt <= holdCnt - 1'b1;
        end
      end
      assign throttleBusy = (holdCnt != '0);
    end else begin : gNoThrottle
      assign throttleBusy = 1'b0;
    end
  endgenerate

  assign kbdAck   = loadNow && winner == SRC_KBD;
  assign mouseAck = loadNow && winner == SRC_MOUSE;

  // Interrupt levels follow the mode byte combinationally.
  assign kbdIrq   = fullQ && !auxQ && modeByte[MODE_KBD_IRQ_EN] && !modeByte[MODE_KBD_OFF];
  assign mouseIrq = fullQ && auxQ && modeByte[MODE_AUX_IRQ_EN];

  assign obFull  = fullQ;
  assign auxFull = auxQ;

  always_comb begin
    strobes.load        = loadNow;
    strobes.src         = winner;
    strobes.respCapture = ctrlRespValid;
  end

endmodule

// File: rtl/obuf_arb_datapath.sv
`timescale 1ns/1ps
module obuf_arb_datapath
  import obuf_arb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] ctrlRespByte,
  input  logic [DATA_W-1:0] kbdByte,
  input  logic [DATA_W-1:0] mouseByte,
  output logic [DATA_W-1:0] readData
);

  logic [DATA_W-1:0] respSlot;
  logic [DATA_W-1:0] bufData;
  logic [DATA_W-1:0] srcBytes [NUM_SRC];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respSlot <= '0;
    end else if (strobes.respCapture) begin
      respSlot <= ctrlRespByte;
    end
  end

  // Candidate bytes laid out by source rank.
  always_comb begin
    srcBytes[SRC_CTRL_KBD] = respSlot;
    srcBytes[SRC_CTRL_AUX] = respSlot;
    srcBytes[SRC_KBD]      = kbdByte;
    srcBytes[SRC_MOUSE]    = mouseByte;
  end

  // Buffer keeps its byte after a read so a repeated read returns it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData <= '0;
    end else if (strobes.load) begin
      bufData <= srcBytes[strobes.src];
    end
  end

  assign readData = bufData;

endmodule

// File: rtl/obuf_arbiter.sv
`timescale 1ns/1ps
module obuf_arbiter
  import obuf_arb_pkg::*;
#(
  parameter bit THROTTLE_EN     = 1'b0,
  parameter int THROTTLE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] modeByte,
  input  logic       ctrlRespValid,
  input  logic       ctrlRespAux,
  input  logic [7:0] ctrlRespByte,
  input  logic       kbdValid,
  input  logic [7:0] kbdByte,
  output logic       kbdAck,
  input  logic       mouseValid,
  input  logic [7:0] mouseByte,
  output logic       mouseAck,
  input  logic       dataRead,
  output logic [7:0] readData,
  output logic       obFull,
  output logic       auxFull,
  output logic       kbdIrq,
  output logic       mouseIrq
);

  strobeT strobes;

  obuf_arb_ctrl #(
    .THROTTLE_EN    (THROTTLE_EN),
    .THROTTLE_CYCLES(THROTTLE_CYCLES)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeByte     (modeByte),
    .ctrlRespValid(ctrlRespValid),
    .ctrlRespAux  (ctrlRespAux),
    .kbdValid     (kbdValid),
    .mouseValid   (mouseValid),
    .dataRead     (dataRead),
    .strobes      (strobes),
    .obFull       (obFull),
    .auxFull      (auxFull),
    .kbdAck       (kbdAck),
    .mouseAck     (mouseAck),
    .kbdIrq       (kbdIrq),
    .mouseIrq     (mouseIrq)
  );

  obuf_arb_datapath #(
    .DATA_W(8)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .ctrlRespByte(ctrlRespByte),
    .kbdByte     (kbdByte),
    .mouseByte   (mouseByte),
    .readData    (readData)
  );

endmodule

// File: rtl/obuf_arbiter_checker.sv
`timescale 1ns/1ps
module obuf_arbiter_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] modeByte,
  input logic       ctrlRespValid,
  input logic       ctrlRespAux,
  input logic [7:0] ctrlRespByte,
  input logic       kbdValid,
  input logic [7:0] kbdByte,
  input logic       kbdAck,
  input logic       mouseValid,
  input logic [7:0] mouseByte,
  input logic       mouseAck,
  input logic       dataRead,
  input logic [7:0] readData,
  input logic       obFull,
  input logic       auxFull,
  input logic       kbdIrq,
  input logic       mouseIrq
);

  assert_mouse_after_kbd_R2: assert property (@(posedge clk) disable iff (!rstN)
    mouseAck |-> !(kbdValid && !modeByte[4]));

  assert_kbd_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    kbdAck |-> kbdValid && !modeByte[4]);

  assert_mouse_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    mouseAck |-> mouseValid && !modeByte[5]);

  assert_aux_needs_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    auxFull |-> obFull);

  assert_kbd_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    kbdAck |=> obFull && !auxFull && readData == $past(kbdByte));

  assert_mouse_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    mouseAck |=> obFull && auxFull && readData == $past(mouseByte));

  assert_kbd_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    kbdIrq |-> obFull && !auxFull && modeByte[0] && !modeByte[4]);

  assert_mouse_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    mouseIrq |-> obFull && auxFull && modeByte[1]);

  assert_irq_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({kbdIrq, mouseIrq}));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    obFull && dataRead |=> !obFull && !kbdIrq && !mouseIrq);

  assert_hold_until_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    obFull && !dataRead |=> obFull && $stable(readData) && $stable(auxFull));

  assert_ack_only_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (kbdAck || mouseAck) |-> !obFull);

  assert_data_only_on_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    !obFull |=> obFull || $stable(readData));

endmodule

bind obuf_arbiter obuf_arbiter_checker uChecker (.*);

// File: tb/obuf_arbiter_test.sv
`timescale 1ns/1ps
module obuf_arbiter_test;

  localparam int TCYC = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] modeByte = 8'h03;
  logic       ctrlRespValid = 1'b0;
  logic       ctrlRespAux = 1'b0;
  logic [7:0] ctrlRespByte = 8'h00;
  logic       kbdValid = 1'b0;
  logic [7:0] kbdByte = 8'h00;
  logic       kbdAck;
  logic       mouseValid = 1'b0;
  logic [7:0] mouseByte = 8'h00;
  logic       mouseAck;
  logic       dataRead = 1'b0;
  logic [7:0] readData;
  logic       obFull;
  logic       auxFull;
  logic       kbdIrq;
  logic       mouseIrq;

  always #4 clk = ~clk;

  obuf_arbiter #(.THROTTLE_EN(1'b1), .THROTTLE_CYCLES(TCYC)) uut (
    .clk(clk), .rstN(rstN), .modeByte(modeByte),
    .ctrlRespValid(ctrlRespValid), .ctrlRespAux(ctrlRespAux), .ctrlRespByte(ctrlRespByte),
    .kbdValid(kbdValid), .kbdByte(kbdByte), .kbdAck(kbdAck),
    .mouseValid(mouseValid), .mouseByte(mouseByte), .mouseAck(mouseAck),
    .dataRead(dataRead), .readData(readData), .obFull(obFull), .auxFull(auxFull),
    .kbdIrq(kbdIrq), .mouseIrq(mouseIrq)
  );

  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  bit         autoRead = 1'b0;
  logic [8:0] expQ [$];
  logic [7:0] kbdQ [$];
  logic [7:0] mouseQ [$];
  logic       kbdAckSeen = 1'b0;
  logic       mouseAckSeen = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard compare of the buffered byte, then one read strobe.
  task automatic doRead(input string req);
    logic [8:0] e;
    if (expQ.size() == 0) begin
      checks++;
      errors++;
      $display("FAIL %s unexpected byte: actual %0h expected none", req, {auxFull, readData});
    end else begin
      e = expQ.pop_front();
      chk(req, "aux+byte", {23'd0, auxFull, readData}, {23'd0, e});
    end
    dataRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dataRead = 1'b0;
  endtask

  task automatic postResp(input logic aux, input logic [7:0] b);
    @(negedge clk);
    ctrlRespValid = 1'b1;
    ctrlRespAux   = aux;
    ctrlRespByte  = b;
    @(negedge clk);
    ctrlRespValid = 1'b0;
  endtask

  // Monitor: drains the buffer when enabled.
  initial begin
    forever begin
      @(negedge clk);
      if (autoRead && obFull) doRead("R2");
    end
  end

  // Device models: ack seen at the edge, byte retired on the next falling edge.
  always @(posedge clk) begin
    kbdAckSeen   <= kbdAck;
    mouseAckSeen <= mouseAck;
  end

  always @(negedge clk) begin
    if (kbdAckSeen && kbdQ.size() != 0) kbdQ.delete(0);
    if (mouseAckSeen && mouseQ.size() != 0) mouseQ.delete(0);
    kbdValid   = (kbdQ.size() != 0);
    kbdByte    = (kbdQ.size() != 0) ? kbdQ[0] : 8'h00;
    mouseValid = (mouseQ.size() != 0);
    mouseByte  = (mouseQ.size() != 0) ? mouseQ[0] : 8'h00;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "obFull", obFull, 0);
    chk("R1", "auxFull", auxFull, 0);
    chk("R1", "kbdIrq", kbdIrq, 0);
    chk("R1", "mouseIrq", mouseIrq, 0);
    chk("R1", "readData", readData, 8'h00);

    // R11 read while empty
    dataRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dataRead = 1'b0;
    chk("R11", "empty read data", readData, 8'h00);
    chk("R11", "empty read full", obFull, 0);

    // Single keyboard byte, interrupts and mode reaction
    kbdQ.push_back(8'h1C);
    expQ.push_back({1'b0, 8'h1C});
    repeat (3) @(negedge clk);
    chk("R4", "kbd obFull", obFull, 1);
    chk("R4", "kbd auxFull", auxFull, 0);
    chk("R5", "kbdIrq", kbdIrq, 1);
    chk("R5", "mouseIrq low", mouseIrq, 0);
    modeByte = 8'h02;
    #1 chk("R12", "kbdIrq off by enable bit", kbdIrq, 0);
    modeByte = 8'h13;
    #1 chk("R5", "kbdIrq off by disable bit", kbdIrq, 0);
    modeByte = 8'h03;
    #1 chk("R12", "kbdIrq back", kbdIrq, 1);
    doRead("R7");
    chk("R7", "full cleared", obFull, 0);
    chk("R7", "kbdIrq cleared", kbdIrq, 0);
    dataRead = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dataRead = 1'b0;
    chk("R11", "last byte again", readData, 8'h1C);
    repeat (TCYC + 5) @(negedge clk);

    // Mouse byte
    mouseQ.push_back(8'h08);
    expQ.push_back({1'b1, 8'h08});
    repeat (3) @(negedge clk);
    chk("R4", "mouse auxFull", auxFull, 1);
    chk("R6", "mouseIrq", mouseIrq, 1);
    chk("R6", "kbdIrq low", kbdIrq, 0);
    modeByte = 8'h01;
    #1 chk("R12", "mouseIrq off", mouseIrq, 0);
    modeByte = 8'h03;
    doRead("R7");
    repeat (3) @(negedge clk);

    // Priority with buffer held full
    kbdQ.push_back(8'h30);
    expQ.push_back({1'b0, 8'h30});
    repeat (3) @(negedge clk);
    postResp(1'b1, 8'hAA);
    mouseQ.push_back(8'h40);
    kbdQ.push_back(8'h31);
    repeat (5) @(negedge clk);
    chk("R8", "held byte", readData, 8'h30);
    chk("R8", "held full", obFull, 1);
    chk("R8", "mouse not acked", mouseValid, 1);
    expQ.push_back({1'b1, 8'hAA});
    expQ.push_back({1'b0, 8'h31});
    expQ.push_back({1'b1, 8'h40});
    autoRead = 1'b1;
    repeat (120) @(negedge clk);
    chk("R2", "priority queue drained", expQ.size(), 0);

    // Response replacement
    autoRead = 1'b0;
    kbdQ.push_back(8'h50);
    expQ.push_back({1'b0, 8'h50});
    repeat (3) @(negedge clk);
    postResp(1'b0, 8'h11);
    postResp(1'b1, 8'h22);
    expQ.push_back({1'b1, 8'h22});
    autoRead = 1'b1;
    repeat (80) @(negedge clk);
    chk("R10", "only newest response", expQ.size(), 0);
    chk("R10", "nothing left", obFull, 0);

    // Masking
    modeByte = 8'h13;
    kbdQ.push_back(8'h60);
    repeat (30) @(negedge clk);
    chk("R3", "kbd masked full", obFull, 0);
    chk("R3", "kbd still offered", kbdValid, 1);
    expQ.push_back({1'b0, 8'h77});
    postResp(1'b0, 8'h77);
    repeat (10) @(negedge clk);
    chk("R3", "response not masked", expQ.size(), 0);
    expQ.push_back({1'b1, 8'h61});
    mouseQ.push_back(8'h61);
    repeat (10) @(negedge clk);
    chk("R3", "mouse passes kbd mask", expQ.size(), 0);
    expQ.push_back({1'b0, 8'h60});
    modeByte = 8'h03;
    repeat (TCYC + 20) @(negedge clk);
    chk("R3", "kbd after unmask", expQ.size(), 0);
    modeByte = 8'h23;
    mouseQ.push_back(8'h62);
    repeat (20) @(negedge clk);
    chk("R3", "mouse masked full", obFull, 0);
    expQ.push_back({1'b1, 8'h62});
    modeByte = 8'h03;
    repeat (20) @(negedge clk);
    chk("R3", "mouse after unmask", expQ.size(), 0);

    // Throttle window and its absence after a mouse read
    autoRead = 1'b0;
    repeat (3) @(negedge clk);
    kbdQ.push_back(8'hA1);
    kbdQ.push_back(8'hA2);
    expQ.push_back({1'b0, 8'hA1});
    expQ.push_back({1'b0, 8'hA2});
    repeat (3) @(negedge clk);
    doRead("R9");
    repeat (TCYC) @(negedge clk);
    chk("R9", "still blocked", obFull, 0);
    @(negedge clk);
    chk("R9", "loaded after window", obFull, 1);
    doRead("R9");
    repeat (TCYC + 5) @(negedge clk);
    mouseQ.push_back(8'hB1);
    mouseQ.push_back(8'hB2);
    expQ.push_back({1'b1, 8'hB1});
    expQ.push_back({1'b1, 8'hB2});
    repeat (3) @(negedge clk);
    doRead("R7");
    @(negedge clk);
    chk("R7", "reload next edge", obFull, 1);
    chk("R7", "reload aux", auxFull, 1);
    doRead("R7");
    repeat (5) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule